// File: doc/BRIEF.md
# I2C Configuration Register Slave with Staged Commit

This block is a two-wire serial slave that holds sixteen 8-bit configuration registers. A bus master sets a register pointer with the first byte after the device address. It then either streams data bytes into the registers or, after a repeated START and the address with the read bit set, streams bytes out. The pointer advances after every byte and wraps within the sixteen locations.

Writes land only in a staging bank. Register 0 is a command byte: each of its eight bits moves one group of staging registers into the active configuration and then clears itself. A group that has never been committed shows a preset value instead. The preset is chosen by two strap inputs while the mode input is low. When the mode input goes high, the strap choice is frozen and the shared strap pins are flagged as outputs. SCL and SDA are sampled with the system clock, and the slave pulls SDA low through an open-drain enable.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave answers only device address 7'b1011100. For any other address it gives no acknowledge, never drives SDA, and leaves every register unchanged.
- R2: A write of pointer P followed by data D stores D in register P (pointer byte bits [3:0]). A later read of P returns D, sent MSB first.
- R3: In a multi-byte write the pointer advances by one after each data byte and wraps from 15 to 0.
- R4: In a multi-byte read the pointer advances by one after each byte sent and wraps from 15 to 0. After the master answers a byte with no acknowledge, the slave releases SDA.
- R5: A data byte is committed to its register on the SCL falling edge that begins the slave's acknowledge, before any STOP.
- R6: A byte cut short by STOP or by a repeated START leaves every register unchanged.
- R7: Command register 0: bit 0, 1 and 2 copy registers 1-3, 4-6 and 7-9; bits 3 to 6 copy registers 10 to 13 one each; bit 7 copies registers 14-15. The copy takes one clock and the bit then reads back 0. The group keeps that copy until its next commit, whatever is written to staging in between.
- R8: After reset all staging registers read 0, SDA is released, strap_oe is 0, and no group is committed.
- R9: Output act_cfg holds register k (1..15) at bits [8k-1:8k-8]. For an uncommitted group, the byte is {sel[1:0], 2'b10, k[3:0]}. sel follows strap_i while mode_i is low.
- R10: While mode_i is high, sel holds its last value whatever strap_i does, and strap_oe is 1.
- R11: A general call (address 0) is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus pad |
| sda_i | input | 1 | Serial data from the bus pad |
| sda_oe | output | 1 | Pull SDA low when 1 |
| mode_i | input | 1 | Low: straps select the preset; high: choice frozen |
| strap_i | input | 2 | Preset select straps |
| strap_oe | output | 1 | Shared strap pins are in output mode |
| act_cfg | output | 120 | Active configuration, registers 1 to 15 |

## Verification
The checks assume that SCL low phases last longer than the synchronizer and edge-detect delay. They also assume SDA moves only while SCL is low, except for START and STOP, and that the master never issues START or STOP while the slave holds SDA low. The bench master keeps to this by moving every line on quarter-bit steps of six clocks. It changes SDA only in the middle of SCL low, and it always gives the final read byte a no-acknowledge before sending STOP.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h5C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_i,
  input  logic         sda_i,
  output logic         sda_oe,
  input  logic         mode_i,
  input  logic [1:0]   strap_i,
  output logic         strap_oe,
  output logic [119:0] act_cfg
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_REG, S_WDAT, S_ACK, S_RDAT, S_RACK} st_t;

  function automatic logic [2:0] grp(input int k);
    if (k <= 3) return 3'd0;
    else if (k <= 6) return 3'd1;
    else if (k <= 9) return 3'd2;
    else if (k <= 13) return 3'(k - 7);
    else return 3'd7;
  endfunction

  logic [1:0] scl_ff, sda_ff, mode_ff, strap_a, strap_b;
  logic       scl_p, sda_p;
  logic [1:0] sel;
  st_t        st, nxt;
  logic [7:0] sh, tx, committed;
  logic [2:0] cnt;
  logic [3:0] ptr;
  logic       full, nak;
  logic [7:0] stage [16];
  logic [7:0] actv [1:15];

  wire scl_s   = scl_ff[1];
  wire sda_s   = sda_ff[1];
  wire rise    = scl_s & ~scl_p;
  wire fall    = ~scl_s & scl_p;
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  wire idle    = (st == S_IDLE);

  assign strap_oe = mode_ff[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff  <= 2'b11;
      sda_ff  <= 2'b11;
      scl_p   <= 1'b1;
      sda_p   <= 1'b1;
      mode_ff <= 2'b00;
      strap_a <= 2'b00;
      strap_b <= 2'b00;
      sel     <= 2'b00;
    end else begin
      scl_ff  <= {scl_ff[0], scl_i};
      sda_ff  <= {sda_ff[0], sda_i};
      scl_p   <= scl_s;
      sda_p   <= sda_s;
      mode_ff <= {mode_ff[0], mode_i};
      strap_a <= strap_i;
      strap_b <= strap_a;
      if (!mode_ff[1]) sel <= strap_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      nxt       <= S_IDLE;
      sh        <= '0;
      tx        <= '0;
      cnt       <= '0;
      ptr       <= '0;
      full      <= 1'b0;
      nak       <= 1'b0;
      sda_oe    <= 1'b0;
      committed <= '0;
      for (int k = 0; k < 16; k++) stage[k] <= '0;
      for (int k = 1; k < 16; k++) actv[k] <= '0;
    end else begin
      for (int k = 1; k < 16; k++)
        if (stage[0][grp(k)]) actv[k] <= stage[k];
      committed <= committed | stage[0];
      if (|stage[0]) stage[0] <= '0;

      if (start_c) begin
        st     <= S_ADDR;
        cnt    <= '0;
        full   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_REG, S_WDAT: begin
            if (rise && !full) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) full <= 1'b1;
            end
            if (fall && full) begin
              full <= 1'b0;
              cnt  <= '0;
              if (st == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  st     <= S_ACK;
                  nxt    <= sh[0] ? S_RDAT : S_REG;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_REG) begin
                ptr    <= sh[3:0];
                sda_oe <= 1'b1;
                st     <= S_ACK;
                nxt    <= S_WDAT;
              end else begin
                stage[ptr] <= sh;
                ptr        <= ptr + 4'd1;
                sda_oe     <= 1'b1;
                st         <= S_ACK;
                nxt        <= S_WDAT;
              end
            end
          end
          S_ACK: if (fall) begin
            cnt <= '0;
            st  <= nxt;
            if (nxt == S_RDAT) begin
              tx     <= stage[ptr];
              sda_oe <= ~stage[ptr][7];
            end else begin
              sda_oe <= 1'b0;
            end
          end
          S_RDAT: if (fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 4'd1;
              st     <= S_RACK;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
              cnt    <= cnt + 3'd1;
            end
          end
          S_RACK: begin
            if (rise) nak <= sda_s;
            if (fall) begin
              if (nak) begin
                st <= S_IDLE;
              end else begin
                tx     <= stage[ptr];
                sda_oe <= ~stage[ptr][7];
                cnt    <= '0;
                st     <= S_RDAT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar k = 1; k < 16; k++) begin : g_out
    assign act_cfg[(k-1)*8 +: 8] = committed[grp(k)] ? actv[k] : {sel, 2'b10, 4'(k)};
  end

endmodule

module cfg_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       mode_s,
  input logic [1:0] sel,
  input logic [7:0] cmd,
  input logic [7:0] committed,
  input logic       idle
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe); // R1

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s)); // R4

  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 8'h00) |=> (cmd == 8'h00)); // R7

  AST_COMMIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((committed & $past(committed)) == $past(committed))); // R7

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && $past(mode_s)) |-> $stable(sel)); // R10

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .mode_s(strap_oe),
  .sel(sel), .cmd(stage[0]), .committed(committed), .idle(idle)
);

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb;

  localparam int Q = 6;
  localparam logic [6:0] DEV = 7'h5C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, mode_i = 1'b0;
  logic [1:0] strap_i = 2'b10;
  logic sda_oe, strap_oe;
  logic [119:0] act_cfg;
  wire sda_line = sda_m & ~sda_oe;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] e_stage [16];
  logic [7:0] e_act [16];
  logic [7:0] e_com = '0;
  logic [1:0] e_sel = 2'b10;

  always #5 clk = ~clk;

  cfg_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .mode_i(mode_i), .strap_i(strap_i), .strap_oe(strap_oe), .act_cfg(act_cfg)
  );

  function automatic int gmap(input int k);
    if (k <= 3) return 0;
    else if (k <= 6) return 1;
    else if (k <= 9) return 2;
    else if (k <= 13) return k - 7;
    else return 7;
  endfunction

  function automatic logic [119:0] expv();
    logic [119:0] v;
    for (int k = 1; k < 16; k++)
      v[(k-1)*8 +: 8] = e_com[gmap(k)] ? e_act[k] : {e_sel, 2'b10, 4'(k)};
    return v;
  endfunction

  task automatic model_commit(input logic [7:0] c);
    for (int k = 1; k < 16; k++) if (c[gmap(k)]) e_act[k] = e_stage[k];
    e_com = e_com | c;
  endtask

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = ~a;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~mack);
  endtask

  task automatic wr_reg(input logic [3:0] r, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    i2c_start();
    wbyte({DEV, 1'b0}, a0); wbyte({4'h0, r}, a1); wbyte(d, a2);
    i2c_stop();
    ok = a0 & a1 & a2;
    e_stage[r] = d;
  endtask

  task automatic rd_reg(input logic [3:0] r, output logic [7:0] d);
    logic a;
    i2c_start();
    wbyte({DEV, 1'b0}, a); wbyte({4'h0, r}, a);
    i2c_start();
    wbyte({DEV, 1'b1}, a);
    rbyte(d, 1'b0);
    i2c_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    logic a;
    chk("R8 sda_oe after reset", sda_oe, 0);
    chk("R8 strap_oe after reset", strap_oe, 0);
    chk("R9 preset after reset", act_cfg, expv());
    i2c_start();
    wbyte({DEV, 1'b0}, a); wbyte(8'h00, a);
    i2c_start();
    wbyte({DEV, 1'b1}, a);
    for (int i = 0; i < 16; i++) begin
      rbyte(d, i != 15);
      chk("R8 staging cleared", d, 0);
    end
    i2c_stop();
  endtask

  task automatic t_preset();
    strap_i = 2'b01; e_sel = 2'b01;
    repeat (10) @(negedge clk);
    chk("R9 preset follows strap", act_cfg, expv());
    chk("R9 strap_oe low", strap_oe, 0);
    mode_i = 1'b1;
    repeat (10) @(negedge clk);
    strap_i = 2'b11;
    repeat (10) @(negedge clk);
    chk("R10 strap frozen", act_cfg, expv());
    chk("R10 strap_oe high", strap_oe, 1);
  endtask

  task automatic t_addr();
    logic a;
    logic [7:0] d;
    i2c_start();
    wbyte({7'h5D, 1'b0}, a);
    chk("R1 wrong address nack", a, 0);
    wbyte(8'h03, a); wbyte(8'hAA, a);
    i2c_stop();
    i2c_start();
    wbyte(8'h00, a);
    chk("R11 general call nack", a, 0);
    wbyte(8'h03, a);
    i2c_stop();
    rd_reg(4'd3, d);
    chk("R1 foreign write ignored", d, 0);
  endtask

  task automatic t_random();
    logic ok;
    logic [7:0] d;
    wr_reg(4'd5, 8'h3C, ok);
    chk("R2 write acked", ok, 1);
    rd_reg(4'd5, d);
    chk("R2 readback", d, 8'h3C);
  endtask

  task automatic t_seq();
    logic a;
    logic [7:0] d;
    logic [7:0] wv [4] = '{8'hE1, 8'hF2, 8'h00, 8'h11};
    i2c_start();
    wbyte({DEV, 1'b0}, a); wbyte(8'h0E, a);
    for (int i = 0; i < 4; i++) wbyte(wv[i], a);
    i2c_stop();
    e_stage[14] = 8'hE1; e_stage[15] = 8'hF2; e_stage[0] = 8'h00; e_stage[1] = 8'h11;
    rd_reg(4'd1, d);
    chk("R3 write wrapped to 1", d, 8'h11);
    rd_reg(4'd15, d);
    chk("R3 write to 15", d, 8'hF2);
    i2c_start();
    wbyte({DEV, 1'b0}, a); wbyte(8'h0D, a);
    i2c_start();
    wbyte({DEV, 1'b1}, a);
    for (int i = 0; i < 5; i++) begin
      rbyte(d, i != 4);
      chk("R4 sequential read", d, e_stage[(13 + i) % 16]);
    end
    chk("R4 SDA released after nack", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic t_abort();
    logic ok, a;
    logic [7:0] d;
    wr_reg(4'd7, 8'h77, ok);
    i2c_start();
    wbyte({DEV, 1'b0}, a); wbyte(8'h07, a);
    wbit(1'b0); wbit(1'b1); wbit(1'b0); wbit(1'b1);
    i2c_start();
    wbyte({DEV, 1'b0}, a); wbyte(8'h08, a);
    wbit(1'b1); wbit(1'b1); wbit(1'b1);
    i2c_stop();
    rd_reg(4'd7, d);
    chk("R6 repeated start discards byte", d, 8'h77);
    rd_reg(4'd8, d);
    chk("R6 stop discards byte", d, 8'h00);
  endtask

  task automatic t_commit();
    logic a, ok;
    logic [7:0] d;
    i2c_start();
    wbyte({DEV, 1'b0}, a); wbyte(8'h00, a); wbyte(8'h01, a);
    model_commit(8'h01);
    chk("R5 commit before stop", act_cfg, expv());
    i2c_stop();
    rd_reg(4'd0, d);
    chk("R7 command bit self-clears", d, 0);
    wr_reg(4'd0, 8'h80, ok); e_stage[0] = 8'h00;
    model_commit(8'h80);
    chk("R7 output group commit", act_cfg, expv());
    wr_reg(4'd1, 8'h99, ok);
    chk("R7 staging isolated", act_cfg, expv());
    wr_reg(4'd0, 8'h06, ok); e_stage[0] = 8'h00;
    model_commit(8'h06);
    chk("R7 groups 1 and 2", act_cfg, expv());
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin e_stage[i] = '0; e_act[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_preset();
    t_addr();
    t_random();
    t_seq();
    t_abort();
    t_commit();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule